// File: doc/BRIEF.md
# PLL Holdover and Lock-Detect Controller

This controller watches the phase-detector activity of a PLL and decides three things: when the loop counts as locked, when the charge pump must be frozen in holdover, and when the loop may be frozen again. A one-cycle strobe marks each phase-detector comparison. A companion flag tells whether both edges of that comparison fell inside the lock window. A run of qualifying comparisons of programmable length raises the lock indicator. A single miss clears it.

Holdover comes from one of two sources. In automatic mode it follows a loss of lock. In external mode it follows a request input. Both are gated by a master enable. After any holdover ends, the controller waits until the loop has locked again and the lock-detect pin reads high before it allows holdover again. The pin is resynchronised inside the block, and the comparator-enable bit can replace it with a constant high. A loss of lock while a reference switchover is under way produces only a brief holdover. That holdover ends at the next comparison strobe.

All control bits are sampled on the clock. The holdover output is taken straight from the state register.

Top module: `pll_hold_ctrl`

## Requirements
- R1: Under reset, and in the cycle after it, `lock_o` and `hold_o` are 0. `state_o` is 0 during reset and reads 1 one edge after reset is released. The encoding of `state_o` is 0 = reset, 1 = acquire, 2 = locked, 3 = holdover, 4 = wait-for-relock.
- R2: `lock_o` rises at the clock edge that samples the Nth consecutive strobe with `win_ok`=1, and not before. N is 5, 16, 64 or 255 for `cnt_code` values 0, 1, 2 or 3.
- R3: A strobe with `win_ok`=0 clears the run and forces `lock_o` to 0 at that same edge.
- R4: A change of `cnt_code` clears the run and `lock_o` at the edge that samples the new value. A strobe at that edge is not counted.
- R5: While `dld_off`=1, `lock_o` stays 0 and automatic holdover never engages. A locked controller falls back to acquire instead.
- R6: While `hold_en`=0, `hold_o` is 0 from the next edge onward, and a loss of lock in the locked state returns the controller to acquire.
- R7: In automatic mode (`ext_sel`=0, `hold_en`=1, `dld_off`=0), a drop of `lock_o` in the locked state sets `hold_o` one edge later.
- R8: In external mode (`ext_sel`=1, `hold_en`=1), `ext_req`=1 sampled together with a strobe in acquire or locked enters holdover at that edge. Holdover lasts while `ext_req` stays 1. Clearing `ext_req` moves the controller to wait-for-relock at the next edge.
- R9: An automatic holdover ends at the edge of a strobe with `win_ok`=1, and the controller moves to wait-for-relock.
- R10: In wait-for-relock no holdover is entered. The controller moves to locked one edge after both `lock_o`=1 and the synchronised pin are high. The pin passes a 2-stage synchroniser.
- R11: With `cmp_en`=0 the pin is treated as high, so the relock condition depends on `lock_o` alone.
- R12: If `swo_active`=1 when automatic holdover is entered, that holdover ends at the next strobe, whatever the value of `win_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfd_strobe | input | 1 | One-cycle pulse per phase-detector comparison |
| win_ok | input | 1 | Both edges inside the lock window (valid with strobe) |
| ld_pin | input | 1 | Asynchronous lock-detect pin comparator level |
| swo_active | input | 1 | Reference switchover in progress |
| hold_en | input | 1 | Master holdover enable |
| ext_sel | input | 1 | 1 = external holdover, 0 = automatic |
| ext_req | input | 1 | External holdover request |
| cmp_en | input | 1 | Pin comparator enable (0 = pin treated as high) |
| dld_off | input | 1 | Digital lock detector disable |
| cnt_code | input | 2 | Lock run length select |
| lock_o | output | 1 | Lock indicator |
| hold_o | output | 1 | Holdover request (freeze charge pump) |
| state_o | output | 3 | Controller state |

## Verification
The hardest case to reach is the blocked re-arm. It needs a completed holdover, then a fresh lock run while the pin is still low, and then the pin rising through its synchroniser. The stimulus gets there by driving the pin low on leaving holdover. It then completes a full qualifying run and confirms the controller stays in wait-for-relock. Finally it turns off the comparator so the pin reads high, and confirms the move to locked at the following edge. The short switchover holdover is reached by raising `swo_active` just before an out-of-window strobe, then sending a second out-of-window strobe to show that release does not depend on `win_ok`.

// File: rtl/pll_hold_pkg.sv
package pll_hold_pkg;
  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_ACQ   = 3'd1,
    ST_LOCK  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_WAIT  = 3'd4
  } hold_st_e;
endpackage

// File: rtl/pll_pin_qual.sv
module pll_pin_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic cmp_en,
  output logic pin_hi
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end
  endgenerate

  // bypass: a disabled comparator reads as permanently high
  assign pin_hi = cmp_en ? sync_q[SYNC_STAGES-1] : 1'b1;
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int N0 = 5,
  parameter int N1 = 16,
  parameter int N2 = 64,
  parameter int N3 = 255,
  localparam int CNT_W = $clog2(N3 + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe,
  input  logic       win_ok,
  input  logic       dld_off,
  input  logic [1:0] cnt_code,
  output logic       lock_q
);
  logic [1:0]       code_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt;

  always_comb begin
    case (code_q)
      2'd0:    tgt = CNT_W'(N0);
      2'd1:    tgt = CNT_W'(N1);
      2'd2:    tgt = CNT_W'(N2);
      default: tgt = CNT_W'(N3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= 2'd0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (cnt_code != code_q) begin
      code_q <= cnt_code;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (dld_off) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (strobe) begin
      if (!win_ok) begin
        cnt_q  <= '0;
        lock_q <= 1'b0;
      end else if (cnt_q >= tgt - 1'b1) begin
        cnt_q  <= tgt;
        lock_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_hold_fsm.sv
module pll_hold_fsm
  import pll_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strobe,
  input  logic     win_ok,
  input  logic     lock,
  input  logic     pin_hi,
  input  logic     swo,
  input  logic     hold_en,
  input  logic     ext_sel,
  input  logic     ext_req,
  input  logic     dld_off,
  output hold_st_e st_q
);
  hold_st_e st_n;
  logic short_q, short_n;
  logic extm_q, extm_n;
  logic ext_go, auto_ok, relock_ok;

  assign ext_go    = hold_en && ext_sel && ext_req && strobe;
  assign auto_ok   = hold_en && !ext_sel && !dld_off;
  assign relock_ok = lock && pin_hi;

  always_comb begin
    st_n    = st_q;
    short_n = short_q;
    extm_n  = extm_q;
    case (st_q)
      ST_RESET: st_n = ST_ACQ;
      ST_ACQ: begin
        if (ext_go) begin
          st_n = ST_HOLD; extm_n = 1'b1; short_n = 1'b0;
        end else if (relock_ok) begin
          st_n = ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (ext_go) begin
          st_n = ST_HOLD; extm_n = 1'b1; short_n = 1'b0;
        end else if (!lock) begin
          if (auto_ok) begin
            st_n = ST_HOLD; extm_n = 1'b0; short_n = swo;
          end else begin
            st_n = ST_ACQ;
          end
        end
      end
      ST_HOLD: begin
        if (!hold_en)                           st_n = ST_WAIT;
        else if (short_q)                       begin if (strobe) st_n = ST_WAIT; end
        else if (extm_q)                        begin if (!(ext_sel && ext_req)) st_n = ST_WAIT; end
        else if (ext_sel || dld_off || (strobe && win_ok)) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (dld_off)        st_n = ST_ACQ;
        else if (relock_ok) st_n = ST_LOCK;
      end
      default: st_n = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RESET;
      short_q <= 1'b0;
      extm_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      short_q <= short_n;
      extm_q  <= extm_n;
    end
  end
endmodule

// File: rtl/pll_hold_ctrl.sv
module pll_hold_ctrl
  import pll_hold_pkg::*;
#(
  parameter int N0 = 5,
  parameter int N1 = 16,
  parameter int N2 = 64,
  parameter int N3 = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pfd_strobe,
  input  logic       win_ok,
  input  logic       ld_pin,
  input  logic       swo_active,
  input  logic       hold_en,
  input  logic       ext_sel,
  input  logic       ext_req,
  input  logic       cmp_en,
  input  logic       dld_off,
  input  logic [1:0] cnt_code,
  output logic       lock_o,
  output logic       hold_o,
  output logic [2:0] state_o
);
  logic     pin_hi;
  logic     lock_q;
  hold_st_e st_q;

  pll_pin_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin_i(ld_pin), .cmp_en(cmp_en), .pin_hi(pin_hi)
  );

  pll_lock_det #(.N0(N0), .N1(N1), .N2(N2), .N3(N3)) u_det (
    .clk(clk), .rst(rst), .strobe(pfd_strobe), .win_ok(win_ok),
    .dld_off(dld_off), .cnt_code(cnt_code), .lock_q(lock_q)
  );

  pll_hold_fsm u_fsm (
    .clk(clk), .rst(rst), .strobe(pfd_strobe), .win_ok(win_ok),
    .lock(lock_q), .pin_hi(pin_hi), .swo(swo_active), .hold_en(hold_en),
    .ext_sel(ext_sel), .ext_req(ext_req), .dld_off(dld_off), .st_q(st_q)
  );

  assign lock_o  = lock_q;
  assign hold_o  = (st_q == ST_HOLD);
  assign state_o = st_q;
endmodule

// File: rtl/pll_hold_ctrl_chk.sv
module pll_hold_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       pfd_strobe,
  input logic       win_ok,
  input logic       hold_en,
  input logic       dld_off,
  input logic       lock_o,
  input logic       hold_o,
  input logic [2:0] state_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0) |-> (!lock_o && !hold_o)); // R1
  AST_LOCK_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(pfd_strobe && win_ok)); // R2
  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (rst)
    (pfd_strobe && !win_ok) |=> !lock_o); // R3
  AST_DLD_OFF_NOLOCK: assert property (@(posedge clk) disable iff (rst)
    dld_off |=> !lock_o); // R5
  AST_HOLD_GATED: assert property (@(posedge clk) disable iff (rst)
    !hold_en |=> !hold_o); // R6
  AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_o) |-> ($past(state_o) == 3'd1 || $past(state_o) == 3'd2)); // R8
  AST_NO_REARM: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4) |=> (state_o != 3'd3)); // R10
endmodule

bind pll_hold_ctrl pll_hold_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pfd_strobe(pfd_strobe), .win_ok(win_ok),
  .hold_en(hold_en), .dld_off(dld_off), .lock_o(lock_o), .hold_o(hold_o),
  .state_o(state_o)
);

// File: tb/pll_hold_ctrl_bench.sv
module pll_hold_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pfd_strobe = 0, win_ok = 0, ld_pin = 0, swo_active = 0;
  logic hold_en = 1, ext_sel = 0, ext_req = 0, cmp_en = 1, dld_off = 0;
  logic [1:0] cnt_code = 2'd0;
  logic lock_o, hold_o;
  logic [2:0] state_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_hold_ctrl u_pll_hold_ctrl (
    .clk(clk), .rst(rst), .pfd_strobe(pfd_strobe), .win_ok(win_ok),
    .ld_pin(ld_pin), .swo_active(swo_active), .hold_en(hold_en),
    .ext_sel(ext_sel), .ext_req(ext_req), .cmp_en(cmp_en), .dld_off(dld_off),
    .cnt_code(cnt_code), .lock_o(lock_o), .hold_o(hold_o), .state_o(state_o)
  );

  typedef struct {
    string tag;
    logic  lk;
    logic  hd;
    int    st;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  bit   done  = 0;

  // monitor: pops expectations half a cycle after the edge they describe
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (lock_o !== e.lk || hold_o !== e.hd || int'(state_o) != e.st) begin
        n_bad++;
        $display("FAIL %s: got lock=%b hold=%b state=%0d, want lock=%b hold=%b state=%0d",
                 e.tag, lock_o, hold_o, state_o, e.lk, e.hd, e.st);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_CYC && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got cycle=%0d, want below %0d", cyc, WDOG_CYC);
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(input logic w);
    pfd_strobe = 1'b1;
    win_ok     = w;
    step();
    pfd_strobe = 1'b0;
    win_ok     = 1'b0;
  endtask

  task automatic expect_now(input string tag, input logic lk, input logic hd, input int st);
    exp_t e;
    e.tag = tag; e.lk = lk; e.hd = hd; e.st = st;
    exp_q.push_back(e);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) strobe(1'b1);
  endtask

  initial begin
    step(); step();
    expect_now("R1 in reset", 0, 0, 0);
    rst = 1'b0;
    step();
    expect_now("R1 after release", 0, 0, 1);

    // R2: code 0 needs five hits; pin low keeps acquire
    run(4);
    expect_now("R2 four hits", 0, 0, 1);
    strobe(1'b1);
    expect_now("R2 fifth hit", 1, 0, 1);
    ld_pin = 1'b1;
    step(); step();
    expect_now("R10 pin in sync", 1, 0, 1);
    step();
    expect_now("R10 locked", 1, 0, 2);

    // R3 / R7: miss drops lock, holdover next edge
    strobe(1'b0);
    expect_now("R3 miss drops lock", 0, 0, 2);
    step();
    expect_now("R7 auto holdover", 0, 1, 3);

    // R9: a miss keeps holdover, a hit releases it
    strobe(1'b0);
    expect_now("R9 miss holds", 0, 1, 3);
    ld_pin = 1'b0;
    strobe(1'b1);
    expect_now("R9 hit releases", 0, 0, 4);

    // R10: relock but pin low keeps waiting
    run(4);
    expect_now("R10 relocked", 1, 0, 4);
    step(); step();
    expect_now("R10 blocked by pin", 1, 0, 4);
    cmp_en = 1'b0;
    step();
    expect_now("R11 bypass relocks", 1, 0, 2);

    // R12: short holdover during switchover
    swo_active = 1'b1;
    strobe(1'b0);
    step();
    expect_now("R12 short entry", 0, 1, 3);
    swo_active = 1'b0;
    strobe(1'b0);
    expect_now("R12 ends on next strobe", 0, 0, 4);
    run(5);
    step();
    expect_now("R10 relock after short", 1, 0, 2);

    // R8: external holdover
    ext_sel = 1'b1; ext_req = 1'b1;
    step();
    expect_now("R8 waits for strobe", 1, 0, 2);
    strobe(1'b1);
    expect_now("R8 external entry", 1, 1, 3);
    step();
    expect_now("R8 held by request", 1, 1, 3);
    ext_req = 1'b0;
    step();
    expect_now("R8 release", 1, 0, 4);
    step();
    expect_now("R8 relock", 1, 0, 2);

    // R6: disabled holdover falls back to acquire
    ext_sel = 1'b0; hold_en = 1'b0;
    strobe(1'b0);
    step();
    expect_now("R6 no holdover", 0, 0, 1);
    hold_en = 1'b1;

    // R5: detector disabled
    dld_off = 1'b1;
    run(6);
    expect_now("R5 no lock when off", 0, 0, 1);
    dld_off = 1'b0;
    run(5);
    step();
    expect_now("R5 relocked", 1, 0, 2);
    dld_off = 1'b1;
    step();
    expect_now("R5 lock dropped", 0, 0, 2);
    step();
    expect_now("R5 no auto holdover", 0, 0, 1);
    dld_off = 1'b0;

    // R4: code change restarts the run; code 1 needs 16
    run(3);
    cnt_code = 2'd1;
    strobe(1'b1);
    run(15);
    expect_now("R4 restart, 15 hits", 0, 0, 1);
    strobe(1'b1);
    expect_now("R2 sixteenth hit", 1, 0, 1);
    step();
    expect_now("R2 locked code 1", 1, 0, 2);
    cnt_code = 2'd0;
    step();
    expect_now("R4 change drops lock", 0, 0, 2);
    cnt_code = 2'd2;
    step();
    expect_now("R7 holdover after code drop", 0, 1, 3);
    strobe(1'b1);
    run(62);
    expect_now("R2 sixty-three hits", 0, 0, 4);
    strobe(1'b1);
    expect_now("R2 sixty-fourth hit", 1, 0, 4);
    step();
    expect_now("R10 locked code 2", 1, 0, 2);

    step(); step();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule